// File: doc/BRIEF.md
# SPI Controller Host Register Block

This block is the host-facing register file of a command-driven SPI controller. A processor reaches it over a simple 32-bit strobe bus with byte offsets. Through this bus it loads 16-bit commands into a command queue and outgoing bytes into a transmit queue. It drains incoming bytes from a receive queue, either removing each entry or only looking at the oldest one. The serial engine behind the block takes entries from the command and transmit queues and fills the receive queue. When the engine finishes a synchronisation command it reports the command's 8-bit tag, so software can tell that a whole command program has completed.

Four interrupt causes share one request line. Three come from queue fill levels and one from the synchronisation event. Each cause is latched into a pending bit that software clears by writing ones. A per-cause enable mask decides which pending bits reach the line. A soft-reset bit, set when the block comes out of reset, empties all three queues and keeps them empty until software clears it. A read-only identification word carries a major, minor and patch number.

Top module: `spi_regif`

## Requirements
- R1: After `rst`, `engine_rst` is 1, the enable and pending masks, the sync tag and `irq` are 0, and all queues are empty, so offset 0xD0 reads 16.
- R2: A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Offset 0x00 reads the identification word: major 1 in bits 23:16, minor in 15:8 and patch in 7:0 (default 0x00010205). Unmapped offsets read 0.
- R3: Bit 0 of offset 0x40 drives `engine_rst`. While it is 1, all queues are emptied and pushes into them are dropped. Writing 0 releases the queues.
- R4: A write to 0xE0 pushes `bus_wdata[15:0]` into the command queue. Entries leave it in order on `cmd_data` while `cmd_valid` is high, one per cycle in which `cmd_pop` is high. Offset 0xD0 reads the depth minus the occupancy.
- R5: A write to 0xE4 pushes `bus_wdata[7:0]` into the transmit queue, which is drained the same way through `tx_data`, `tx_valid` and `tx_pop`. Offset 0xD4 reads the depth minus the occupancy.
- R6: `rx_push` stores `rx_data` in the receive queue. Offset 0xD8 reads the occupancy. A read of 0xE8 returns the oldest entry and removes it. A read of 0xEC returns the oldest entry and leaves it in place.
- R7: A push into a full queue is dropped. A read of 0xE8 or 0xEC with an empty receive queue returns 0 and changes nothing.
- R8: Offset 0x80 holds the 4-bit enable mask. The cause bits are: bit 0 command queue almost empty, bit 1 transmit queue almost empty, bit 2 receive queue almost full, bit 3 sync event.
- R9: Pending bit 0 (or bit 1) is set one cycle after a cycle in which the command (or transmit) occupancy is at most 4. Pending bit 2 is set one cycle after a cycle in which the receive occupancy is at least 12. These bits set again after clearing for as long as the condition holds.
- R10: Writing 0x84 clears each pending bit whose data bit is 1 and leaves the bits whose data bit is 0. A set and a clear of the same bit in the same cycle leave it set.
- R11: `sync_stb` copies `sync_id` into the register at 0xC0 and sets pending bit 3.
- R12: Offset 0x88 reads pending AND enable, and `irq` is the OR of that vector, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| engine_rst | output | 1 | Soft reset to the serial engine |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_data | output | 16 | Oldest command |
| cmd_pop | input | 1 | Engine takes the oldest command |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| rx_push | input | 1 | Engine stores a received byte |
| rx_data | input | 8 | Received byte |
| sync_stb | input | 1 | Sync command executed |
| sync_id | input | 8 | Tag of that sync command |

## Verification
The hardest case to reach from the ports is one cycle in which a pending bit is both set by its cause and cleared by a software write. The bench forces it by driving `sync_stb` in the same cycle as a clear write to bit 3. It also holds a queue at its almost-empty level while clearing that bit, which shows the bit setting again. Queue overflow and empty reads are reached by pushing past the depth and popping past empty. A long random phase then mixes bus accesses, engine pops and pushes, soft-reset toggles and sync strobes. A queue-based model checks the block against all of this every cycle.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  // Byte offsets seen by software
  localparam logic [7:0] A_VERSION  = 8'h00;
  localparam logic [7:0] A_SOFTRST  = 8'h40;
  localparam logic [7:0] A_IRQ_EN   = 8'h80;
  localparam logic [7:0] A_IRQ_PEND = 8'h84;
  localparam logic [7:0] A_IRQ_SRC  = 8'h88;
  localparam logic [7:0] A_SYNC_ID  = 8'hC0;
  localparam logic [7:0] A_CMD_ROOM = 8'hD0;
  localparam logic [7:0] A_TX_ROOM  = 8'hD4;
  localparam logic [7:0] A_RX_LEVEL = 8'hD8;
  localparam logic [7:0] A_CMD_PUSH = 8'hE0;
  localparam logic [7:0] A_TX_PUSH  = 8'hE4;
  localparam logic [7:0] A_RX_POP   = 8'hE8;
  localparam logic [7:0] A_RX_PEEK  = 8'hEC;

  // Interrupt cause positions
  localparam int IRQ_N     = 4;
  localparam int IB_CMD_AE = 0;
  localparam int IB_TX_AE  = 1;
  localparam int IB_RX_AF  = 2;
  localparam int IB_SYNC   = 3;

  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/regif_fifo.sv
module regif_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic [CNTW-1:0] count
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt != CNTW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  assign dout  = mem[rp];
  assign count = cnt;
endmodule

// File: rtl/regif_irq.sv
module regif_irq
  import spi_regif_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t cond,
  input  logic     clr_we,
  input  irq_vec_t clr_mask,
  input  logic     en_we,
  input  irq_vec_t en_din,
  output irq_vec_t pend,
  output irq_vec_t en,
  output logic     irq
);
  irq_vec_t clr;

  assign clr = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      // a cause present this cycle wins over a clear
      pend <= (pend & ~clr) | cond;
      if (en_we) en <= en_din;
      irq  <= |(pend & en);
    end
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int         CMD_W      = 16,
  parameter int         DATA_W     = 8,
  parameter int         FIFO_DEPTH = 16,
  parameter int         CMD_AE_LVL = 4,
  parameter int         TX_AE_LVL  = 4,
  parameter int         RX_AF_LVL  = 12,
  parameter logic [7:0] VER_MAJOR  = 8'd1,
  parameter logic [7:0] VER_MINOR  = 8'd2,
  parameter logic [7:0] VER_PATCH  = 8'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              engine_rst,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              sync_stb,
  input  logic [7:0]        sync_id
);
  localparam int          CNTW     = $clog2(FIFO_DEPTH + 1);
  localparam logic [31:0] VER_WORD = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
  localparam logic [31:0] DEPTH32  = 32'(FIFO_DEPTH);

  logic              soft_q;
  logic [7:0]        sid_q;
  logic [31:0]       rdata_q;
  irq_vec_t          pend_q, en_q, cond;
  logic [CNTW-1:0]   cmd_cnt, tx_cnt, rx_cnt;
  logic [DATA_W-1:0] rx_head;
  logic [31:0]       rx_head32;
  logic              wr_soft, wr_en, wr_pend, wr_cmd, wr_tx, rx_pop;

  assign wr_soft = bus_wr && (bus_addr == A_SOFTRST);
  assign wr_en   = bus_wr && (bus_addr == A_IRQ_EN);
  assign wr_pend = bus_wr && (bus_addr == A_IRQ_PEND);
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD_PUSH);
  assign wr_tx   = bus_wr && (bus_addr == A_TX_PUSH);
  assign rx_pop  = bus_rd && (bus_addr == A_RX_POP);

  regif_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) cmd_q (
    .clk(clk), .rst(rst), .flush(soft_q),
    .push(wr_cmd), .din(bus_wdata[CMD_W-1:0]),
    .pop(cmd_pop), .dout(cmd_data), .count(cmd_cnt)
  );

  regif_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) tx_q (
    .clk(clk), .rst(rst), .flush(soft_q),
    .push(wr_tx), .din(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop), .dout(tx_data), .count(tx_cnt)
  );

  regif_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rx_q (
    .clk(clk), .rst(rst), .flush(soft_q),
    .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt)
  );

  assign cmd_valid = (cmd_cnt != '0);
  assign tx_valid  = (tx_cnt != '0);
  assign rx_head32 = (rx_cnt != '0) ? 32'(rx_head) : 32'h0;

  always_comb begin
    cond            = '0;
    cond[IB_CMD_AE] = (cmd_cnt <= CNTW'(CMD_AE_LVL));
    cond[IB_TX_AE]  = (tx_cnt <= CNTW'(TX_AE_LVL));
    cond[IB_RX_AF]  = (rx_cnt >= CNTW'(RX_AF_LVL));
    cond[IB_SYNC]   = sync_stb;
  end

  regif_irq irq_u (
    .clk(clk), .rst(rst), .cond(cond),
    .clr_we(wr_pend), .clr_mask(bus_wdata[IRQ_N-1:0]),
    .en_we(wr_en), .en_din(bus_wdata[IRQ_N-1:0]),
    .pend(pend_q), .en(en_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b1;
      sid_q  <= '0;
    end else begin
      if (wr_soft)  soft_q <= bus_wdata[0];
      if (sync_stb) sid_q  <= sync_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_VERSION:  rdata_q <= VER_WORD;
        A_SOFTRST:  rdata_q <= {31'h0, soft_q};
        A_IRQ_EN:   rdata_q <= 32'(en_q);
        A_IRQ_PEND: rdata_q <= 32'(pend_q);
        A_IRQ_SRC:  rdata_q <= 32'(pend_q & en_q);
        A_SYNC_ID:  rdata_q <= {24'h0, sid_q};
        A_CMD_ROOM: rdata_q <= DEPTH32 - 32'(cmd_cnt);
        A_TX_ROOM:  rdata_q <= DEPTH32 - 32'(tx_cnt);
        A_RX_LEVEL: rdata_q <= 32'(rx_cnt);
        A_RX_POP:   rdata_q <= rx_head32;
        A_RX_PEEK:  rdata_q <= rx_head32;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata  = rdata_q;
  assign engine_rst = soft_q;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int CNTW   = 5,
  parameter int DEPTH  = 16,
  parameter int CMD_AE = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            irq,
  input logic            engine_rst,
  input logic            cmd_valid,
  input logic            tx_valid,
  input logic            sync_stb,
  input logic [7:0]      sync_id,
  input logic [3:0]      pend,
  input logic [3:0]      en,
  input logic [7:0]      sid,
  input logic [CNTW-1:0] cmd_cnt
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq && engine_rst && pend == 4'h0 && en == 4'h0));

  // R3
  soft_flush_chk: assert property (@(posedge clk) disable iff (rst)
    engine_rst |=> (!cmd_valid && !tx_valid));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_cnt <= CNTW'(DEPTH));

  // R9
  cmd_ae_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_cnt <= CNTW'(CMD_AE)) |=> pend[0]);

  // R11
  sync_capture_chk: assert property (@(posedge clk) disable iff (rst)
    sync_stb |=> (pend[3] && sid == $past(sync_id)));

  // R12
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend & en)) |=> irq);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & en)) |=> !irq);
endmodule

bind spi_regif spi_regif_chk #(
  .CNTW(CNTW), .DEPTH(FIFO_DEPTH), .CMD_AE(CMD_AE_LVL)
) chk_i (
  .clk(clk), .rst(rst), .irq(irq), .engine_rst(engine_rst),
  .cmd_valid(cmd_valid), .tx_valid(tx_valid),
  .sync_stb(sync_stb), .sync_id(sync_id),
  .pend(pend_q), .en(en_q), .sid(sid_q), .cmd_cnt(cmd_cnt)
);

// File: tb/spi_regif_test.sv
`timescale 1ns/1ps
module spi_regif_test;
  localparam int DEPTH  = 16;
  localparam int CMD_AE = 4;
  localparam int TX_AE  = 4;
  localparam int RX_AF  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, engine_rst, cmd_valid, tx_valid;
  logic [15:0] cmd_data;
  logic [7:0]  tx_data;
  logic        cmd_pop = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, sync_stb = 1'b0;
  logic [7:0]  rx_data = '0, sync_id = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  spi_regif uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .engine_rst(engine_rst),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data),
    .sync_stb(sync_stb), .sync_id(sync_id)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] mq_cmd[$];
  logic [7:0]  mq_tx[$];
  logic [7:0]  mq_rx[$];
  logic        m_soft, m_irq;
  logic [3:0]  m_en, m_pend;
  logic [7:0]  m_sid;
  logic [31:0] m_rdata;
  string       m_tag = "R1";

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h40: return "R3";
      8'h80: return "R8";
      8'h84: return "R10";
      8'h88: return "R12";
      8'hC0: return "R11";
      8'hD0: return "R4";
      8'hD4: return "R5";
      8'hD8, 8'hE8, 8'hEC: return "R6";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return 32'h00010205;
      8'h40: return {31'h0, m_soft};
      8'h80: return {28'h0, m_en};
      8'h84: return {28'h0, m_pend};
      8'h88: return {28'h0, m_pend & m_en};
      8'hC0: return {24'h0, m_sid};
      8'hD0: return DEPTH - mq_cmd.size();
      8'hD4: return DEPTH - mq_tx.size();
      8'hD8: return mq_rx.size();
      8'hE8, 8'hEC: return (mq_rx.size() > 0) ? {24'h0, mq_rx[0]} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [3:0] cond, clr;
    bit cpush, cpop, tpush, tpop, rpush, rpop;
    if (rst) begin
      mq_cmd.delete(); mq_tx.delete(); mq_rx.delete();
      m_soft = 1'b1; m_irq = 1'b0; m_en = '0; m_pend = '0;
      m_sid = '0; m_rdata = '0;
    end else begin
      cond = {sync_stb, mq_rx.size() >= RX_AF, mq_tx.size() <= TX_AE,
              mq_cmd.size() <= CMD_AE};
      clr  = (bus_wr && bus_addr == 8'h84) ? bus_wdata[3:0] : 4'h0;
      m_irq = |(m_pend & m_en);
      if (bus_rd) begin
        m_rdata = m_read(bus_addr);
        m_tag   = tag_of(bus_addr);
      end
      cpush = bus_wr && bus_addr == 8'hE0 && mq_cmd.size() < DEPTH;
      cpop  = cmd_pop && mq_cmd.size() > 0;
      tpush = bus_wr && bus_addr == 8'hE4 && mq_tx.size() < DEPTH;
      tpop  = tx_pop && mq_tx.size() > 0;
      rpush = rx_push && mq_rx.size() < DEPTH;
      rpop  = bus_rd && bus_addr == 8'hE8 && mq_rx.size() > 0;
      if (m_soft) begin
        mq_cmd.delete(); mq_tx.delete(); mq_rx.delete();
      end else begin
        if (cpop)  void'(mq_cmd.pop_front());
        if (cpush) mq_cmd.push_back(bus_wdata[15:0]);
        if (tpop)  void'(mq_tx.pop_front());
        if (tpush) mq_tx.push_back(bus_wdata[7:0]);
        if (rpop)  void'(mq_rx.pop_front());
        if (rpush) mq_rx.push_back(rx_data);
      end
      m_pend = (m_pend & ~clr) | cond;
      if (bus_wr && bus_addr == 8'h80) m_en = bus_wdata[3:0];
      if (bus_wr && bus_addr == 8'h40) m_soft = bus_wdata[0];
      if (sync_stb) m_sid = sync_id;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_rdata === m_rdata, m_tag, bus_rdata, m_rdata);
      chk(irq === m_irq, "R12", {31'h0, irq}, {31'h0, m_irq});
      chk(engine_rst === m_soft, "R3", {31'h0, engine_rst}, {31'h0, m_soft});
      chk(cmd_valid === (mq_cmd.size() > 0), "R4", {31'h0, cmd_valid},
          {31'h0, mq_cmd.size() > 0});
      if (mq_cmd.size() > 0)
        chk(cmd_data === mq_cmd[0], "R4", {16'h0, cmd_data}, {16'h0, mq_cmd[0]});
      chk(tx_valid === (mq_tx.size() > 0), "R5", {31'h0, tx_valid},
          {31'h0, mq_tx.size() > 0});
      if (mq_tx.size() > 0)
        chk(tx_data === mq_tx[0], "R5", {24'h0, tx_data}, {24'h0, mq_tx[0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp,
                           input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [7:0] addr_set [14] = '{8'h00, 8'h40, 8'h80, 8'h84, 8'h88, 8'hC0, 8'hD0,
                                8'hD4, 8'hD8, 8'hE0, 8'hE4, 8'hE8, 8'hEC, 8'h3C};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(engine_rst === 1'b1 && irq === 1'b0, "R1", {30'h0, engine_rst, irq}, 32'h2);
    rd_expect(8'h40, 32'h1, "R1");
    rd_expect(8'hD0, DEPTH, "R1");
    rd_expect(8'hC0, 32'h0, "R1");
    // R2 identification and unmapped
    rd_expect(8'h00, 32'h00010205, "R2");
    rd_expect(8'h3C, 32'h0, "R2");

    // R3 push while held is dropped
    bus_write(8'hE0, 32'h0000_ABCD);
    rd_expect(8'hD0, DEPTH, "R3");
    bus_write(8'h40, 32'h0);
    rd_expect(8'h40, 32'h0, "R3");

    // R8 enable mask, R9 almost-empty causes at empty queues
    bus_write(8'h80, 32'hF);
    rd_expect(8'h80, 32'hF, "R8");
    rd_expect(8'h84, 32'h3, "R9");
    rd_expect(8'h88, 32'h3, "R12");
    chk(irq === 1'b1, "R12", {31'h0, irq}, 32'h1);

    // R4 / R7: fill command queue one past full
    for (int i = 0; i < DEPTH + 1; i++) bus_write(8'hE0, 32'h1000 + i);
    rd_expect(8'hD0, 32'h0, "R7");
    chk(cmd_data === 16'h1000, "R4", {16'h0, cmd_data}, 32'h1000);
    // R10 clear bit 0 while the queue is full; R9 bit 1 sets again
    bus_write(8'h84, 32'h1);
    rd_expect(8'h84, 32'h2, "R10");
    bus_write(8'h84, 32'h2);
    rd_expect(8'h84, 32'h2, "R9");
    @(negedge clk); cmd_pop = 1'b1;
    repeat (DEPTH) @(negedge clk);
    cmd_pop = 1'b0;
    rd_expect(8'hD0, DEPTH, "R4");

    // R5 transmit queue
    for (int i = 0; i < 5; i++) bus_write(8'hE4, 32'h30 + i);
    @(negedge clk); tx_pop = 1'b1;
    repeat (3) @(negedge clk);
    tx_pop = 1'b0;
    chk(tx_data === 8'h33, "R5", {24'h0, tx_data}, 32'h33);
    rd_expect(8'hD4, DEPTH - 2, "R5");

    // R6 / R7 receive queue, overfilled
    for (int i = 0; i < DEPTH + 4; i++) begin
      @(negedge clk); rx_push = 1'b1; rx_data = 8'hA0 + 8'(i);
    end
    @(negedge clk); rx_push = 1'b0;
    rd_expect(8'hD8, DEPTH, "R7");
    rd_expect(8'h84, 32'h7, "R9");
    rd_expect(8'hEC, 32'hA0, "R6");
    rd_expect(8'hEC, 32'hA0, "R6");
    rd_expect(8'hE8, 32'hA0, "R6");
    rd_expect(8'hE8, 32'hA1, "R6");
    for (int i = 0; i < DEPTH - 2; i++) bus_read(8'hE8);
    rd_expect(8'hE8, 32'h0, "R7");
    rd_expect(8'hEC, 32'h0, "R7");
    rd_expect(8'hD8, 32'h0, "R7");

    // R11 sync capture
    @(negedge clk); sync_stb = 1'b1; sync_id = 8'h5A;
    @(negedge clk); sync_stb = 1'b0;
    rd_expect(8'hC0, 32'h5A, "R11");
    rd_expect(8'h84, 32'hF, "R11");
    bus_write(8'h84, 32'hFF);
    rd_expect(8'h84, 32'h3, "R10");
    // R10 set and clear of bit 3 in one cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h8;
    sync_stb = 1'b1; sync_id = 8'h77;
    @(negedge clk);
    bus_wr = 1'b0; sync_stb = 1'b0;
    rd_expect(8'h84, 32'hB, "R10");
    rd_expect(8'hC0, 32'h77, "R11");

    // R12 source and line with one cause enabled
    bus_write(8'h80, 32'h8);
    rd_expect(8'h88, 32'h8, "R12");
    chk(irq === 1'b1, "R12", {31'h0, irq}, 32'h1);
    bus_write(8'h84, 32'h8);
    rd_expect(8'h88, 32'h0, "R12");
    chk(irq === 1'b0, "R12", {31'h0, irq}, 32'h0);

    // R3 soft reset flushes filled queues
    for (int i = 0; i < 3; i++) bus_write(8'hE4, 32'h50 + i);
    rd_expect(8'hD4, DEPTH - 5, "R5");
    bus_write(8'h40, 32'h1);
    rd_expect(8'hD4, DEPTH, "R3");
    chk(tx_valid === 1'b0, "R3", {31'h0, tx_valid}, 32'h0);
    bus_write(8'h40, 32'h0);

    // random phase, checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_rd    = ($urandom_range(0, 2) == 0);
      bus_addr  = addr_set[$urandom_range(0, 13)];
      bus_wdata = $urandom;
      if (bus_addr == 8'h40 && $urandom_range(0, 3) != 0) bus_wdata[0] = 1'b0;
      cmd_pop   = $urandom_range(0, 1);
      tx_pop    = $urandom_range(0, 1);
      rx_push   = $urandom_range(0, 1);
      rx_data   = 8'($urandom);
      sync_stb  = ($urandom_range(0, 15) == 0);
      sync_id   = 8'($urandom);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; cmd_pop = 1'b0; tx_pop = 1'b0;
    rx_push = 1'b0; sync_stb = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule